// File: doc/BRIEF.md
# Functional Unit Token Processor

This block is the control shadow of one functional unit in a coarse-grained reconfigurable array. It sits between the fetch and execute stages and runs one cycle ahead of the arithmetic datapath. The datapath itself is outside this block. Other producers in the array send one-bit tokens to it. A token on an operand line means data arrives on that line in the next cycle. Each token carries a staging-predicate bit alongside it.

From the line on which a token arrives, the block works out the select value for each operand multiplexer. It asks the configuration store for the opcode and destination fields only when some token shows that the unit will work next cycle. It decodes the opcode into a token kind (data or predicate) and a result latency. It then places an outgoing token in a delay line, so that the token reaches the one or two consumers named by the destination fields exactly that many cycles after the execute cycle.

An operation whose staging predicate is false is squashed: it does not fire. Its token is still forwarded with the predicate cleared, so that the operations below it inherit the squash.

Top module: `fu_token_unit`

## Requirements
- R1: `fetch_en` is high in the same cycle as any bit of `tok_a` or `tok_b` is high, and low in every other cycle.
- R2: The cycle after tokens arrive is the execute cycle. In that cycle `sel_a` (and `sel_b`) equals the binary index of the asserted bit of `tok_a` (of `tok_b`), or 0 if that operand had no token. At most one bit per operand is high at a time.
- R3: `op_valid` is high exactly in the cycle after a cycle in which `fetch_en` was high.
- R4: The staging predicate of an operation is the AND of the `pred_a`/`pred_b` bits at the positions of its asserted tokens. `op_fire` is high in the execute cycle only when `op_valid` is high and that predicate is 1.
- R5: The opcode is sampled in the execute cycle. Bits [1:0] give latency L = value + 1, from 1 to 4. The outgoing token appears on `out_tok` exactly L cycles after the execute cycle and is absent in the other cycles. `out_kind` equals opcode bit 2 (0 = data token, 1 = predicate token).
- R6: In the output cycle, bit i of `out_tok` is 1 exactly when (`cfg_dst0_vld` and `cfg_dst0` = i) or (`cfg_dst1_vld` and `cfg_dst1` = i), as sampled in the execute cycle. At most two bits are set. If neither field is valid, no token is emitted.
- R7: A squashed operation still emits its token, with `out_stage` = 0. A firing operation emits `out_stage` = 1. When `out_tok` is zero, `out_kind` and `out_stage` are 0.
- R8: If no tokens arrive, `fetch_en`, `op_valid`, `op_fire` and `out_tok` stay 0, whatever the configuration inputs hold.
- R9: While `rst_n` is low, all registered outputs are 0.
- R10: Operations may issue in consecutive cycles. Each one emits its own token at its own latency, so a later short-latency operation may emit before an earlier long-latency one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tok_a | input | N_SRC | Operand A token lines, one per possible producer |
| pred_a | input | N_SRC | Staging-predicate bit for each operand A line |
| tok_b | input | N_SRC | Operand B token lines |
| pred_b | input | N_SRC | Staging-predicate bit for each operand B line |
| fetch_en | output | 1 | Read enable for the opcode and destination fields |
| cfg_opc | input | OPC_W | Opcode field, valid in the execute cycle |
| cfg_dst0 | input | DST_W | First destination consumer index |
| cfg_dst0_vld | input | 1 | First destination field present |
| cfg_dst1 | input | DST_W | Second destination consumer index |
| cfg_dst1_vld | input | 1 | Second destination field present |
| op_valid | output | 1 | Unit executes this cycle |
| op_fire | output | 1 | Execution commits (staging predicate true) |
| sel_a | output | SEL_W | Operand A multiplexer select |
| sel_b | output | SEL_W | Operand B multiplexer select |
| out_tok | output | N_DST | Outgoing token, one bit per consumer |
| out_kind | output | 1 | Outgoing token kind: 0 data, 1 predicate |
| out_stage | output | 1 | Staging predicate carried by the outgoing token |

## Verification
The assertions assume two things about the inputs. First, each operand receives at most one token per cycle. Second, the scheduler never lets two operations land in the same output slot of the delay line. The bench keeps to both. It drives one-hot or empty token vectors. In its sweep it spaces operations further apart than the longest latency, and it checks back-to-back issue only with latency pairs whose output slots are distinct. During the cycles between operations it drives unrelated values on the configuration inputs, so that any leak of those fields would show on the outputs.

// File: rtl/fu_tok_pkg.sv
package fu_tok_pkg;

    // Kind of token sent to consumers
    typedef enum logic {
        TK_DATA = 1'b0,
        TK_PRED = 1'b1
    } tok_kind_e;

endpackage

// File: rtl/fu_tok_rx.sv
// Operand token receiver: turns a one-hot token vector into a mux select
// and picks up the staging predicate of the asserted line.
module fu_tok_rx #(
    parameter int N_SRC = 4,
    parameter int SEL_W = 2
) (
    input  logic [N_SRC-1:0] tok,
    input  logic [N_SRC-1:0] pred,
    output logic             hit,
    output logic [SEL_W-1:0] sel,
    output logic             stage
);

    typedef struct packed {
        logic             hit;
        logic [SEL_W-1:0] sel;
        logic             stage;
    } rx_t;

    rx_t rx_d;

    always_comb begin
        rx_d       = '0;
        rx_d.stage = 1'b1;   // an absent operand does not guard the operation
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (tok[i]) begin
                rx_d.hit   = 1'b1;
                rx_d.sel   = SEL_W'(i);
                rx_d.stage = pred[i];
            end
        end
    end

    assign hit   = rx_d.hit;
    assign sel   = rx_d.sel;
    assign stage = rx_d.stage;

endmodule

// File: rtl/fu_tok_opdec.sv
// Opcode processor: token kind and the delay-line slot matching the latency.
module fu_tok_opdec
    import fu_tok_pkg::*;
#(
    parameter int OPC_W   = 3,
    parameter int LAT_MAX = 4,
    parameter int LAT_W   = 2
) (
    input  logic [OPC_W-1:0] opc,
    output logic [LAT_W-1:0] slot,
    output tok_kind_e        kind
);

    logic [LAT_W-1:0] lat_field;

    assign lat_field = opc[LAT_W-1:0];
    assign kind      = tok_kind_e'(opc[OPC_W-1]);

    generate
        if (LAT_MAX == (1 << LAT_W)) begin : g_full
            assign slot = lat_field;
        end else begin : g_clamp
            localparam logic [LAT_W-1:0] TOP = LAT_W'(LAT_MAX - 1);
            assign slot = (lat_field > TOP) ? TOP : lat_field;
        end
    endgenerate

endmodule

// File: rtl/fu_tok_dst.sv
// Destination expansion: two indexed fields to a consumer bit mask.
module fu_tok_dst #(
    parameter int N_DST = 8,
    parameter int DST_W = 3
) (
    input  logic [DST_W-1:0] dst0,
    input  logic             dst0_vld,
    input  logic [DST_W-1:0] dst1,
    input  logic             dst1_vld,
    output logic [N_DST-1:0] mask
);

    generate
        for (genvar i = 0; i < N_DST; i++) begin : g_cons
            assign mask[i] = (dst0_vld && (dst0 == DST_W'(i))) ||
                             (dst1_vld && (dst1 == DST_W'(i)));
        end
    endgenerate

endmodule

// File: rtl/fu_tok_delay.sv
// Latency delay line: a pushed token enters slot L-1 and leaves at slot 0.
module fu_tok_delay
    import fu_tok_pkg::*;
#(
    parameter int N_DST   = 8,
    parameter int LAT_MAX = 4,
    parameter int LAT_W   = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [LAT_W-1:0] push_slot,
    input  logic [N_DST-1:0] push_mask,
    input  tok_kind_e        push_kind,
    input  logic             push_stage,
    output logic [N_DST-1:0] out_mask,
    output tok_kind_e        out_kind,
    output logic             out_stage
);

    typedef struct packed {
        logic [N_DST-1:0] mask;
        tok_kind_e        kind;
        logic             stage;
    } slot_t;

    slot_t line_d [LAT_MAX];
    slot_t line_q [LAT_MAX];

    always_comb begin
        for (int k = 0; k < LAT_MAX - 1; k++) begin
            line_d[k] = line_q[k+1];
        end
        line_d[LAT_MAX-1] = '0;
        if (push) begin
            line_d[push_slot] = '{mask: push_mask, kind: push_kind, stage: push_stage};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < LAT_MAX; k++) begin
                line_q[k] <= '0;
            end
        end else begin
            for (int k = 0; k < LAT_MAX; k++) begin
                line_q[k] <= line_d[k];
            end
        end
    end

    assign out_mask  = line_q[0].mask;
    assign out_kind  = line_q[0].kind;
    assign out_stage = line_q[0].stage;

endmodule

// File: rtl/fu_token_unit.sv
// Token-processing unit of one functional unit, one cycle ahead of execute.
module fu_token_unit
    import fu_tok_pkg::*;
#(
    parameter int N_SRC   = 4,
    parameter int N_DST   = 8,
    parameter int LAT_MAX = 4,
    parameter int OPC_W   = 3,
    localparam int SEL_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int DST_W  = (N_DST > 1) ? $clog2(N_DST) : 1,
    localparam int LAT_W  = (LAT_MAX > 1) ? $clog2(LAT_MAX) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] tok_a,
    input  logic [N_SRC-1:0] pred_a,
    input  logic [N_SRC-1:0] tok_b,
    input  logic [N_SRC-1:0] pred_b,
    output logic             fetch_en,
    input  logic [OPC_W-1:0] cfg_opc,
    input  logic [DST_W-1:0] cfg_dst0,
    input  logic             cfg_dst0_vld,
    input  logic [DST_W-1:0] cfg_dst1,
    input  logic             cfg_dst1_vld,
    output logic             op_valid,
    output logic             op_fire,
    output logic [SEL_W-1:0] sel_a,
    output logic [SEL_W-1:0] sel_b,
    output logic [N_DST-1:0] out_tok,
    output logic             out_kind,
    output logic             out_stage
);

    localparam int N_OPND = 2;

    typedef struct packed {
        logic             vld;
        logic [SEL_W-1:0] sel_a;
        logic [SEL_W-1:0] sel_b;
        logic             stg;
    } exec_t;

    logic [N_SRC-1:0] rx_tok   [N_OPND];
    logic [N_SRC-1:0] rx_pred  [N_OPND];
    logic             rx_hit   [N_OPND];
    logic [SEL_W-1:0] rx_sel   [N_OPND];
    logic             rx_stage [N_OPND];

    assign rx_tok[0]  = tok_a;
    assign rx_pred[0] = pred_a;
    assign rx_tok[1]  = tok_b;
    assign rx_pred[1] = pred_b;

    generate
        for (genvar g = 0; g < N_OPND; g++) begin : g_rx
            fu_tok_rx #(.N_SRC(N_SRC), .SEL_W(SEL_W)) u_rx (
                .tok   (rx_tok[g]),
                .pred  (rx_pred[g]),
                .hit   (rx_hit[g]),
                .sel   (rx_sel[g]),
                .stage (rx_stage[g])
            );
        end
    endgenerate

    exec_t ex_d;
    exec_t ex_q;

    always_comb begin
        ex_d       = '0;
        ex_d.vld   = rx_hit[0] | rx_hit[1];
        ex_d.sel_a = rx_sel[0];
        ex_d.sel_b = rx_sel[1];
        ex_d.stg   = rx_stage[0] & rx_stage[1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ex_q <= '0;
        end else begin
            ex_q <= ex_d;
        end
    end

    // Opcode and destination fields are only meaningful in the execute cycle.
    logic [LAT_W-1:0] dec_slot;
    tok_kind_e        dec_kind;
    logic [N_DST-1:0] dst_mask;
    logic             push;
    tok_kind_e        line_kind;

    fu_tok_opdec #(.OPC_W(OPC_W), .LAT_MAX(LAT_MAX), .LAT_W(LAT_W)) u_opdec (
        .opc  (cfg_opc),
        .slot (dec_slot),
        .kind (dec_kind)
    );

    fu_tok_dst #(.N_DST(N_DST), .DST_W(DST_W)) u_dst (
        .dst0     (cfg_dst0),
        .dst0_vld (cfg_dst0_vld),
        .dst1     (cfg_dst1),
        .dst1_vld (cfg_dst1_vld),
        .mask     (dst_mask)
    );

    assign push = ex_q.vld && (dst_mask != '0);

    fu_tok_delay #(.N_DST(N_DST), .LAT_MAX(LAT_MAX), .LAT_W(LAT_W)) u_delay (
        .clk        (clk),
        .rst_n      (rst_n),
        .push       (push),
        .push_slot  (dec_slot),
        .push_mask  (dst_mask),
        .push_kind  (dec_kind),
        .push_stage (ex_q.stg),
        .out_mask   (out_tok),
        .out_kind   (line_kind),
        .out_stage  (out_stage)
    );

    assign out_kind = line_kind;
    assign fetch_en = ex_d.vld;
    assign op_valid = ex_q.vld;
    assign op_fire  = ex_q.vld & ex_q.stg;
    assign sel_a    = ex_q.sel_a;
    assign sel_b    = ex_q.sel_b;

endmodule

// File: rtl/fu_tok_chk.sv
// Property checker for fu_token_unit.
module fu_tok_chk #(
    parameter int N_SRC   = 4,
    parameter int N_DST   = 8,
    parameter int LAT_MAX = 4,
    parameter int SEL_W   = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic [N_SRC-1:0] tok_a,
    input logic [N_SRC-1:0] pred_a,
    input logic [N_SRC-1:0] tok_b,
    input logic             fetch_en,
    input logic             op_valid,
    input logic             op_fire,
    input logic [SEL_W-1:0] sel_a,
    input logic [SEL_W-1:0] sel_b,
    input logic [N_DST-1:0] out_tok,
    input logic             out_kind,
    input logic             out_stage
);

    // Cycles since the last execute cycle, saturating.
    logic [7:0] since_exec;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_exec <= 8'hFF;
        end else if (op_valid) begin
            since_exec <= 8'd1;
        end else if (since_exec != 8'hFF) begin
            since_exec <= since_exec + 8'd1;
        end
    end

    a_r2_onehot_tokens: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(tok_a) && $onehot0(tok_b));

    a_r2_sel_a_on_token: assert property (@(posedge clk) disable iff (!rst_n)
        (|tok_a) |=> (($past(tok_a) & (N_SRC'(1) << sel_a)) != '0));

    a_r2_sel_b_on_token: assert property (@(posedge clk) disable iff (!rst_n)
        (|tok_b) |=> (($past(tok_b) & (N_SRC'(1) << sel_b)) != '0));

    a_r3_fetch_then_exec: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_en |=> op_valid);

    a_r3_no_fetch_no_exec: assert property (@(posedge clk) disable iff (!rst_n)
        !fetch_en |=> !op_valid);

    a_r4_fire_needs_exec: assert property (@(posedge clk) disable iff (!rst_n)
        op_fire |-> op_valid);

    a_r4_false_pred_squash: assert property (@(posedge clk) disable iff (!rst_n)
        (|(tok_a & ~pred_a)) |=> !op_fire);

    a_r6_two_dest_max: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(out_tok) <= 2);

    a_r7_idle_fields_low: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tok == '0) |-> (!out_kind && !out_stage));

    a_r8_out_follows_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (out_tok != '0) |-> (since_exec >= 8'd1 && since_exec <= 8'(LAT_MAX)));

endmodule

bind fu_token_unit fu_tok_chk #(
    .N_SRC   (N_SRC),
    .N_DST   (N_DST),
    .LAT_MAX (LAT_MAX),
    .SEL_W   (SEL_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_a     (tok_a),
    .pred_a    (pred_a),
    .tok_b     (tok_b),
    .fetch_en  (fetch_en),
    .op_valid  (op_valid),
    .op_fire   (op_fire),
    .sel_a     (sel_a),
    .sel_b     (sel_b),
    .out_tok   (out_tok),
    .out_kind  (out_kind),
    .out_stage (out_stage)
);

// File: tb/fu_token_unit_test.sv
module fu_token_unit_test;

    localparam int CLK_P   = 10;
    localparam int N_SRC   = 4;
    localparam int N_DST   = 8;
    localparam int LAT_MAX = 4;
    localparam int OPC_W   = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] tok_a = '0, pred_a = '0, tok_b = '0, pred_b = '0;
    logic [2:0] cfg_opc = '0;
    logic [2:0] cfg_dst0 = '0, cfg_dst1 = '0;
    logic       cfg_dst0_vld = 1'b0, cfg_dst1_vld = 1'b0;
    logic       fetch_en, op_valid, op_fire, out_kind, out_stage;
    logic [1:0] sel_a, sel_b;
    logic [7:0] out_tok;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    fu_token_unit #(.N_SRC(N_SRC), .N_DST(N_DST), .LAT_MAX(LAT_MAX), .OPC_W(OPC_W)) uut (
        .clk(clk), .rst_n(rst_n),
        .tok_a(tok_a), .pred_a(pred_a), .tok_b(tok_b), .pred_b(pred_b),
        .fetch_en(fetch_en),
        .cfg_opc(cfg_opc), .cfg_dst0(cfg_dst0), .cfg_dst0_vld(cfg_dst0_vld),
        .cfg_dst1(cfg_dst1), .cfg_dst1_vld(cfg_dst1_vld),
        .op_valid(op_valid), .op_fire(op_fire), .sel_a(sel_a), .sel_b(sel_b),
        .out_tok(out_tok), .out_kind(out_kind), .out_stage(out_stage)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic junk_cfg(input int seed);
        cfg_opc      = 3'((seed * 5 + 3) % 8);
        cfg_dst0     = 3'((seed * 7 + 1) % 8);
        cfg_dst1     = 3'((seed * 3 + 6) % 8);
        cfg_dst0_vld = 1'b1;
        cfg_dst1_vld = 1'b1;
    endtask

    // Full sweep: every token position pair, predicate pair and opcode
    task automatic sweep();
        for (int ia = 0; ia <= N_SRC; ia++) begin
            for (int ib = 0; ib <= N_SRC; ib++) begin
                for (int pc = 0; pc < 4; pc++) begin
                    for (int opc = 0; opc < 8; opc++) begin
                        bit any, stg;
                        int lat, d0, d1;
                        bit d0v, d1v;
                        logic [7:0] mask;
                        any = (ia < N_SRC) || (ib < N_SRC);
                        stg = ((ia < N_SRC) ? pc[0] : 1'b1) & ((ib < N_SRC) ? pc[1] : 1'b1);
                        lat = (opc % 4) + 1;
                        d0  = (ia + 2 * ib) % 8;
                        d1  = (ib * 3 + pc + 1) % 8;
                        d0v = ((opc + ia) % 3) != 0;
                        d1v = ((ia + ib + pc) % 2) == 0;
                        mask = '0;
                        if (d0v) mask[d0] = 1'b1;
                        if (d1v) mask[d1] = 1'b1;
                        if (!any) mask = '0;

                        @(negedge clk);
                        tok_a  = (ia < N_SRC) ? 4'(1 << ia) : 4'h0;
                        tok_b  = (ib < N_SRC) ? 4'(1 << ib) : 4'h0;
                        pred_a = pc[0] ? 4'hF : 4'h0;
                        pred_b = pc[1] ? 4'hF : 4'h0;
                        junk_cfg(ia + ib + opc);
                        #1;
                        chk(fetch_en == any, "R1 fetch_en", int'(fetch_en), int'(any));
                        if (!any) chk(fetch_en == 1'b0, "R8 no fetch without tokens", int'(fetch_en), 0);

                        @(negedge clk);
                        tok_a = '0; tok_b = '0;
                        cfg_opc = 3'(opc);
                        cfg_dst0 = 3'(d0); cfg_dst0_vld = d0v;
                        cfg_dst1 = 3'(d1); cfg_dst1_vld = d1v;
                        #1;
                        chk(op_valid == any, "R3 op_valid", int'(op_valid), int'(any));
                        chk(sel_a == 2'((ia < N_SRC) ? ia : 0), "R2 sel_a", int'(sel_a), (ia < N_SRC) ? ia : 0);
                        chk(sel_b == 2'((ib < N_SRC) ? ib : 0), "R2 sel_b", int'(sel_b), (ib < N_SRC) ? ib : 0);
                        chk(op_fire == (any && stg), "R4 op_fire", int'(op_fire), int'(any && stg));

                        for (int k = 1; k <= LAT_MAX + 1; k++) begin
                            @(negedge clk);
                            junk_cfg(k + opc);
                            #1;
                            if (k == lat) begin
                                chk(out_tok == mask, "R5 R6 out_tok at latency", int'(out_tok), int'(mask));
                                if (mask != '0) begin
                                    chk(out_kind == 1'(opc >> 2), "R5 out_kind", int'(out_kind), opc >> 2);
                                    chk(out_stage == stg, "R7 out_stage", int'(out_stage), int'(stg));
                                end
                            end else begin
                                chk(out_tok == '0, "R5 R8 out_tok off latency", int'(out_tok), 0);
                            end
                            if (out_tok == '0) begin
                                chk(!out_kind && !out_stage, "R7 idle fields", int'({out_kind, out_stage}), 0);
                            end
                            chk(op_valid == 1'b0, "R8 no exec while idle", int'(op_valid), 0);
                        end
                    end
                end
            end
        end
    endtask

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        #1;
        chk(op_valid == 1'b0, "R9 reset op_valid", int'(op_valid), 0);
        chk(op_fire == 1'b0, "R9 reset op_fire", int'(op_fire), 0);
        chk(out_tok == '0, "R9 reset out_tok", int'(out_tok), 0);
        chk({sel_a, sel_b} == '0, "R9 reset selects", int'({sel_a, sel_b}), 0);
        chk(!out_kind && !out_stage, "R9 reset out fields", int'({out_kind, out_stage}), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // Idle with changing configuration inputs: nothing happens
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            junk_cfg(i);
            #1;
            chk(fetch_en == 1'b0, "R8 idle fetch_en", int'(fetch_en), 0);
            chk(op_valid == 1'b0, "R8 idle op_valid", int'(op_valid), 0);
            chk(out_tok == '0, "R8 idle out_tok", int'(out_tok), 0);
        end

        sweep();

        // Back-to-back issue, latency 2, destination = issue index
        for (int c = 0; c <= 7; c++) begin
            @(negedge clk);
            tok_a  = (c < 4) ? 4'(1 << c) : 4'h0;
            pred_a = 4'hF;
            tok_b  = '0;
            if (c >= 1 && c <= 4) begin
                cfg_opc = 3'd1;
                cfg_dst0 = 3'(c - 1); cfg_dst0_vld = 1'b1; cfg_dst1_vld = 1'b0;
            end else begin
                junk_cfg(c);
            end
            #1;
            if (c >= 1 && c <= 4)
                chk(sel_a == 2'(c - 1), "R10 back-to-back sel_a", int'(sel_a), c - 1);
            if (c >= 3 && c <= 6)
                chk(out_tok == 8'(1 << (c - 3)), "R10 back-to-back out_tok", int'(out_tok), 1 << (c - 3));
            else
                chk(out_tok == '0, "R10 back-to-back gap", int'(out_tok), 0);
        end

        // Reordering: latency 3 followed next cycle by latency 1
        @(negedge clk);
        tok_a = 4'h1; pred_a = 4'hF; junk_cfg(2);
        @(negedge clk);
        tok_a = 4'h2; pred_a = 4'h0;
        cfg_opc = 3'd2; cfg_dst0 = 3'd5; cfg_dst0_vld = 1'b1; cfg_dst1_vld = 1'b0;
        @(negedge clk);
        tok_a = '0;
        cfg_opc = 3'd4; cfg_dst0 = 3'd2; cfg_dst0_vld = 1'b1; cfg_dst1 = 3'd6; cfg_dst1_vld = 1'b1;
        @(negedge clk);
        junk_cfg(9);
        #1;
        chk(out_tok == 8'h44, "R10 short op first", int'(out_tok), 8'h44);
        chk(out_kind == 1'b1, "R10 R5 short op kind", int'(out_kind), 1);
        chk(out_stage == 1'b0, "R10 R7 short op squashed stage", int'(out_stage), 0);
        @(negedge clk);
        #1;
        chk(out_tok == 8'h20, "R10 long op second", int'(out_tok), 8'h20);
        chk(out_stage == 1'b1, "R10 R7 long op stage", int'(out_stage), 1);
        @(negedge clk);
        #1;
        chk(out_tok == '0, "R10 line drained", int'(out_tok), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog all requirements actual=%0d expected=%0d", 200000, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule